// File: doc/BRIEF.md
# Port-Mapped Disk Command Sequencer

This block sits beside an 8-bit processor's I/O space and turns a sequence of output-port writes into framed commands for a remote sector server. Software first sets up the disk state. It writes a filename one character at a time, a three-byte seek offset and a 16-bit DMA pointer, each to its own port. It then writes a command code. The block sends the command as a byte stream on a valid/ready transmit channel, collects the server's reply on a valid/ready receive channel, and moves 128-byte sector payloads between the stream and a memory port at the DMA pointer.

Each command is one code byte, optionally followed by a payload. Open-type commands send the filename and a zero terminator. The seek command sends the offset low byte first. The block-write command sends 128 bytes fetched from memory. The server answers every command with one status byte. The block-read command and the directory command may then be followed by data, which is stored to memory. A busy bit, visible on the status output, covers the whole exchange. Port writes made while busy are dropped.

Both streams follow the usual rules. A byte moves only in a cycle where valid and ready are both high. `tx_valid` is never withdrawn, and `tx_data` never changes, while the sink holds `tx_ready` low. The sink may hold `tx_ready` low for any number of cycles, and the block simply waits. `rx_ready` is raised only while a reply byte is expected, so the server's stream is stalled at all other times. Memory writes complete in their own cycle. Memory reads return data on the cycle after `mem_re`.

Top module: `dsk_cmd_seq`

## Requirements
- R1: After reset `sts_rd` reads 0x00, and `tx_valid`, `rx_ready`, `mem_we` and `mem_re` are all low.
- R2: Writing 0x01, 0x02, 0x03 or 0x07 to command port 0x12 sends that code, then the buffered filename characters in the order written, then 0x00. After the zero byte is sent the filename buffer is empty, so the next open-type command sends only its code and 0x00.
- R3: Characters written to port 0x13 are buffered up to 16. Further characters are dropped until the buffer is emptied.
- R4: Command 0x08 sends 0x08 and then the bytes last written to ports 0x14, 0x15 and 0x19, in that order (low, middle, high).
- R5: Commands 0x04, 0x05 and 0x06 send only the code byte. After that the block raises `rx_ready` and waits for the status byte.
- R6: Writing 0x00 to port 0x18 sends 0x10 and receives a status byte. If the status is 0x00, the next 128 received bytes are written to memory at consecutive addresses starting at the DMA pointer.
- R7: Writing 0x01 to port 0x18 sends 0x11, then the 128 memory bytes starting at the DMA pointer, in rising address order. It then waits for a status byte.
- R8: Ports 0x16 and 0x17 load the DMA pointer's low and high byte. The pointer advances by one for each byte moved and wraps from 0xFFFF to 0x0000. It keeps its advanced value after the command ends.
- R9: `sts_rd` bit 7 is the busy flag and bit 0 is bit 0 of the last status byte received (0x00 ok, 0x01 error). Bits 6..1 read zero.
- R10: Busy rises the cycle after an accepted command write and falls after the last byte of the reply is accepted. Any port write made while busy, including one in that final cycle, has no effect.
- R11: After command 0x06 with status 0x00, received bytes are written to memory from the DMA pointer up to and including a 0x00 byte. Block-read and directory payloads are expected only after status 0x00; any other status ends the command.
- R12: A command-port value outside 0x01..0x08, a port-0x18 value other than 0 or 1, and writes to unlisted ports start nothing.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable. `rx_ready` is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pw_valid | input | 1 | Port write strobe, one cycle per write |
| pw_port | input | 8 | Port number of the write |
| pw_data | input | 8 | Data byte of the write |
| sts_rd | output | 8 | Status read value: busy in bit 7, error in bit 0 |
| tx_valid | output | 1 | Byte toward the server is valid |
| tx_ready | input | 1 | Server side accepts the byte |
| tx_data | output | 8 | Byte toward the server |
| rx_valid | input | 1 | Byte from the server is valid |
| rx_ready | output | 1 | Block accepts a byte from the server |
| rx_data | input | 8 | Byte from the server |
| mem_addr | output | 16 | Memory address, equal to the DMA pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
Two things can happen in the same cycle: the final reply byte of a block read is accepted, and software writes a new DMA low byte. The bench provokes this by raising `rx_valid` for byte 128 and `pw_valid` to port 0x16 in the same cycle. Busy is still set in that cycle, so the write must be lost. The bench judges this by issuing a second block read and checking that its first memory address continues straight on from the first transfer, including across the 0xFFFF wrap.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

  // I/O port numbers decoded by the register bank
  localparam logic [7:0] PORT_CMD    = 8'h12;
  localparam logic [7:0] PORT_NAME   = 8'h13;
  localparam logic [7:0] PORT_OFF0   = 8'h14;
  localparam logic [7:0] PORT_OFF1   = 8'h15;
  localparam logic [7:0] PORT_DMA_LO = 8'h16;
  localparam logic [7:0] PORT_DMA_HI = 8'h17;
  localparam logic [7:0] PORT_XFER   = 8'h18;
  localparam logic [7:0] PORT_OFF2   = 8'h19;

  // Wire codes of the server protocol
  typedef enum logic [7:0] {
    OP_OPEN_RD  = 8'h01,
    OP_CREATE   = 8'h02,
    OP_APPEND   = 8'h03,
    OP_REWIND   = 8'h04,
    OP_CLOSE    = 8'h05,
    OP_LIST     = 8'h06,
    OP_OPEN_RW  = 8'h07,
    OP_SEEK     = 8'h08,
    OP_BLK_RD   = 8'h10,
    OP_BLK_WR   = 8'h11
  } op_e;

  // Sequencer phases
  typedef enum logic [3:0] {
    S_IDLE,
    S_CODE,
    S_NAME,
    S_NUL,
    S_OFF,
    S_MRD,
    S_MCAP,
    S_WSEND,
    S_STAT,
    S_DATA,
    S_LIST
  } phase_e;

  function automatic logic takes_name(input op_e op);
    return (op == OP_OPEN_RD) || (op == OP_CREATE) ||
           (op == OP_APPEND)  || (op == OP_OPEN_RW);
  endfunction

endpackage

// File: rtl/dsk_regs.sv
module dsk_regs
  import dsk_pkg::*;
#(
  parameter  int NAME_MAX = 16,
  localparam int IDXW     = $clog2(NAME_MAX),
  localparam int LENW     = $clog2(NAME_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pw_valid,
  input  logic [7:0]      pw_port,
  input  logic [7:0]      pw_data,
  input  logic            busy,
  input  logic            name_clr,
  input  logic            dma_inc,
  input  logic [IDXW-1:0] name_idx,
  output logic            req_valid,
  output op_e             req_op,
  output logic [LENW-1:0] name_len,
  output logic [7:0]      name_char,
  output logic [23:0]     offset,
  output logic [15:0]     dma
);

  logic       wr_ok;
  logic [7:0] name_mem [NAME_MAX];

  assign wr_ok = pw_valid && !busy;

  // Command decode: only legal codes start the sequencer
  always_comb begin
    req_valid = 1'b0;
    req_op    = OP_CLOSE;
    if (wr_ok) begin
      if (pw_port == PORT_CMD) begin
        case (pw_data)
          8'h01, 8'h02, 8'h03, 8'h04,
          8'h05, 8'h06, 8'h07, 8'h08: begin
            req_valid = 1'b1;
            req_op    = op_e'(pw_data);
          end
          default: ;
        endcase
      end else if (pw_port == PORT_XFER) begin
        if (pw_data == 8'h00) begin
          req_valid = 1'b1;
          req_op    = OP_BLK_RD;
        end else if (pw_data == 8'h01) begin
          req_valid = 1'b1;
          req_op    = OP_BLK_WR;
        end
      end
    end
  end

  // Filename storage: contents need no reset, the length gates use
  always_ff @(posedge clk) begin
    if (wr_ok && pw_port == PORT_NAME && name_len < LENW'(NAME_MAX))
      name_mem[name_len[IDXW-1:0]] <= pw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      name_len <= '0;
    end else if (name_clr) begin
      name_len <= '0;
    end else if (wr_ok && pw_port == PORT_NAME && name_len < LENW'(NAME_MAX)) begin
      name_len <= name_len + LENW'(1);
    end
  end

  assign name_char = name_mem[name_idx];

  // Seek offset bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
    end else if (wr_ok) begin
      case (pw_port)
        PORT_OFF0: offset[7:0]   <= pw_data;
        PORT_OFF1: offset[15:8]  <= pw_data;
        PORT_OFF2: offset[23:16] <= pw_data;
        default: ;
      endcase
    end
  end

  // DMA pointer: loads only when idle, advances only when busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma <= '0;
    end else if (dma_inc) begin
      dma <= dma + 16'd1;
    end else if (wr_ok && pw_port == PORT_DMA_LO) begin
      dma[7:0] <= pw_data;
    end else if (wr_ok && pw_port == PORT_DMA_HI) begin
      dma[15:8] <= pw_data;
    end
  end

endmodule

// File: rtl/dsk_txsel.sv
module dsk_txsel
  import dsk_pkg::*;
(
  input  phase_e      phase,
  input  op_e         op,
  input  logic [7:0]  name_char,
  input  logic [23:0] offset,
  input  logic [1:0]  off_sel,
  input  logic [7:0]  hold,
  output logic [7:0]  tx_data
);

  always_comb begin
    case (phase)
      S_CODE:  tx_data = op;
      S_NAME:  tx_data = name_char;
      S_OFF: begin
        case (off_sel)
          2'd0:    tx_data = offset[7:0];
          2'd1:    tx_data = offset[15:8];
          default: tx_data = offset[23:16];
        endcase
      end
      S_WSEND: tx_data = hold;
      default: tx_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/dsk_seq.sv
module dsk_seq
  import dsk_pkg::*;
#(
  parameter  int BLK_BYTES = 128,
  parameter  int NAME_MAX  = 16,
  localparam int IDXW      = $clog2(NAME_MAX),
  localparam int LENW      = $clog2(NAME_MAX + 1),
  localparam int CW        = $clog2(BLK_BYTES + NAME_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  op_e             req_op,
  input  logic [LENW-1:0] name_len,
  input  logic            tx_ready,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic [7:0]      mem_rdata,
  output phase_e          phase,
  output op_e             op,
  output logic            busy,
  output logic            name_clr,
  output logic [IDXW-1:0] name_idx,
  output logic [1:0]      off_sel,
  output logic [7:0]      hold,
  output logic            dma_inc,
  output logic            tx_valid,
  output logic            rx_ready,
  output logic            mem_we,
  output logic            mem_re,
  output logic            sts_err
);

  logic [CW-1:0] cnt;
  logic          rx_go;
  logic          tx_go;

  assign busy     = (phase != S_IDLE);
  assign tx_valid = (phase == S_CODE) || (phase == S_NAME) || (phase == S_NUL) ||
                    (phase == S_OFF)  || (phase == S_WSEND);
  assign rx_ready = (phase == S_STAT) || (phase == S_DATA) || (phase == S_LIST);
  assign mem_re   = (phase == S_MRD);
  assign tx_go    = tx_valid && tx_ready;
  assign rx_go    = rx_valid && rx_ready;
  assign mem_we   = rx_go && ((phase == S_DATA) || (phase == S_LIST));
  assign dma_inc  = mem_we || (phase == S_MCAP);
  assign name_clr = tx_go && (phase == S_NUL);
  assign name_idx = cnt[IDXW-1:0];
  assign off_sel  = cnt[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      op      <= OP_CLOSE;
      cnt     <= '0;
      hold    <= '0;
      sts_err <= 1'b0;
    end else begin
      case (phase)
        S_IDLE: begin
          if (req_valid) begin
            op    <= req_op;
            cnt   <= '0;
            phase <= S_CODE;
          end
        end
        S_CODE: begin
          if (tx_go) begin
            cnt <= '0;
            if (takes_name(op))
              phase <= (name_len == '0) ? S_NUL : S_NAME;
            else if (op == OP_SEEK)
              phase <= S_OFF;
            else if (op == OP_BLK_WR)
              phase <= S_MRD;
            else
              phase <= S_STAT;
          end
        end
        S_NAME: begin
          if (tx_go) begin
            cnt <= cnt + CW'(1);
            if ((cnt + CW'(1)) == CW'(name_len))
              phase <= S_NUL;
          end
        end
        S_NUL: begin
          if (tx_go) phase <= S_STAT;
        end
        S_OFF: begin
          if (tx_go) begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(2))
              phase <= S_STAT;
          end
        end
        S_MRD: begin
          phase <= S_MCAP;
        end
        S_MCAP: begin
          hold  <= mem_rdata;
          phase <= S_WSEND;
        end
        S_WSEND: begin
          if (tx_go) begin
            cnt <= cnt + CW'(1);
            phase <= (cnt == CW'(BLK_BYTES - 1)) ? S_STAT : S_MRD;
          end
        end
        S_STAT: begin
          if (rx_go) begin
            sts_err <= rx_data[0];
            cnt     <= '0;
            if (rx_data == 8'h00 && op == OP_BLK_RD)
              phase <= S_DATA;
            else if (rx_data == 8'h00 && op == OP_LIST)
              phase <= S_LIST;
            else
              phase <= S_IDLE;
          end
        end
        S_DATA: begin
          if (rx_go) begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(BLK_BYTES - 1))
              phase <= S_IDLE;
          end
        end
        S_LIST: begin
          if (rx_go && rx_data == 8'h00)
            phase <= S_IDLE;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsk_cmd_seq.sv
module dsk_cmd_seq
  import dsk_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int NAME_MAX  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pw_valid,
  input  logic [7:0]  pw_port,
  input  logic [7:0]  pw_data,
  output logic [7:0]  sts_rd,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata
);

  localparam int IDXW = $clog2(NAME_MAX);
  localparam int LENW = $clog2(NAME_MAX + 1);

  logic            busy;
  logic            req_valid;
  op_e             req_op;
  op_e             op;
  phase_e          phase;
  logic [LENW-1:0] name_len;
  logic [7:0]      name_char;
  logic [IDXW-1:0] name_idx;
  logic            name_clr;
  logic [23:0]     offset;
  logic [1:0]      off_sel;
  logic [15:0]     dma;
  logic            dma_inc;
  logic [7:0]      hold;
  logic            sts_err;

  dsk_regs #(.NAME_MAX(NAME_MAX)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pw_valid  (pw_valid),
    .pw_port   (pw_port),
    .pw_data   (pw_data),
    .busy      (busy),
    .name_clr  (name_clr),
    .dma_inc   (dma_inc),
    .name_idx  (name_idx),
    .req_valid (req_valid),
    .req_op    (req_op),
    .name_len  (name_len),
    .name_char (name_char),
    .offset    (offset),
    .dma       (dma)
  );

  dsk_seq #(.BLK_BYTES(BLK_BYTES), .NAME_MAX(NAME_MAX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .name_len  (name_len),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .mem_rdata (mem_rdata),
    .phase     (phase),
    .op        (op),
    .busy      (busy),
    .name_clr  (name_clr),
    .name_idx  (name_idx),
    .off_sel   (off_sel),
    .hold      (hold),
    .dma_inc   (dma_inc),
    .tx_valid  (tx_valid),
    .rx_ready  (rx_ready),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .sts_err   (sts_err)
  );

  dsk_txsel u_txsel (
    .phase     (phase),
    .op        (op),
    .name_char (name_char),
    .offset    (offset),
    .off_sel   (off_sel),
    .hold      (hold),
    .tx_data   (tx_data)
  );

  assign mem_addr  = dma;
  assign mem_wdata = rx_data;
  assign sts_rd    = {busy, 6'b000000, sts_err};

endmodule

// File: rtl/dsk_cmd_seq_chk.sv
module dsk_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pw_valid,
  input logic        busy,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        rx_ready,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr
);

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R13
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pw_valid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !mem_we && !mem_re);

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we || (mem_addr == $past(mem_addr) + 16'd1));

endmodule

bind dsk_cmd_seq dsk_cmd_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pw_valid (pw_valid),
  .busy     (busy),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .rx_ready (rx_ready),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr)
);

// File: tb/dsk_cmd_seq_tb.sv
module dsk_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pw_valid = 1'b0;
  logic [7:0]  pw_port = '0;
  logic [7:0]  pw_data = '0;
  logic [7:0]  sts_rd;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_re;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int txn    = 0;
  int wr_cnt = 0;
  logic [15:0] wr_first;
  logic [15:0] wr_last;
  logic [7:0]  txq [0:255];
  logic [7:0]  mem [0:1023];
  logic        stall_en = 1'b0;

  always #4 clk = ~clk;

  dsk_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_port(pw_port),
    .pw_data(pw_data), .sts_rd(sts_rd), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  // Server-side byte collector
  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      txq[txn[7:0]] = tx_data;
      txn = txn + 1;
    end
  end

  // Memory model: write in cycle, read data one cycle later
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] = mem_wdata;
      if (wr_cnt == 0) wr_first = mem_addr;
      wr_last = mem_addr;
      wr_cnt = wr_cnt + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  // Optional back-pressure on the transmit stream
  always @(negedge clk) tx_ready <= stall_en ? ~tx_ready : 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic port_wr(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    pw_valid = 1'b1; pw_port = p; pw_data = d;
    @(negedge clk);
    pw_valid = 1'b0;
  endtask

  task automatic wait_tx(input int n);
    for (int t = 0; t < 5000 && txn < n; t++) @(negedge clk);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    for (int t = 0; t < 2000; t++) begin
      #1;
      if (rx_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", {24'd0, sts_rd}, 32'h00);
    check("R1 strobes", {28'd0, tx_valid, rx_ready, mem_we, mem_re}, 32'h0);
  endtask

  task automatic t_open();
    txn = 0;
    port_wr(8'h13, "A");
    port_wr(8'h13, "B");
    port_wr(8'h12, 8'h01);
    wait_tx(4);
    check("R2 frame", {txq[0], txq[1], txq[2], txq[3]}, {8'h01, "A", "B", 8'h00});
    check("R9 busy in status", {24'd0, sts_rd}, 32'h80);
    rx_byte(8'h00);
    check("R10 busy cleared", {24'd0, sts_rd}, 32'h00);
    txn = 0;
    port_wr(8'h12, 8'h07);
    wait_tx(2);
    repeat (3) @(negedge clk);
    check("R2 buffer cleared", {txn[7:0], txq[0], txq[1]}, {8'd2, 8'h07, 8'h00});
    rx_byte(8'h00);
  endtask

  task automatic t_name_limit();
    int bad = 0;
    txn = 0;
    for (int i = 0; i < 18; i++) port_wr(8'h13, 8'h61 + 8'(i));
    port_wr(8'h12, 8'h02);
    wait_tx(18);
    repeat (4) @(negedge clk);
    check("R3 frame length", txn, 18);
    for (int i = 0; i < 16; i++) if (txq[i+1] !== 8'h61 + 8'(i)) bad++;
    check("R3 characters kept", bad, 0);
    check("R3 terminator", {24'd0, txq[17]}, 32'h00);
    rx_byte(8'h01);
    check("R9 error status", {24'd0, sts_rd}, 32'h01);
  endtask

  task automatic t_seek();
    txn = 0;
    port_wr(8'h19, 8'h33);
    port_wr(8'h14, 8'h11);
    port_wr(8'h15, 8'h22);
    port_wr(8'h12, 8'h08);
    wait_tx(4);
    check("R4 seek frame", {txq[0], txq[1], txq[2], txq[3]}, 32'h08112233);
    rx_byte(8'h00);
    check("R9 ok status", {24'd0, sts_rd}, 32'h00);
  endtask

  task automatic t_short();
    txn = 0;
    port_wr(8'h12, 8'h05);
    wait_tx(1);
    repeat (3) @(negedge clk);
    check("R5 close single byte", {txn[7:0], txq[0], 7'd0, rx_ready}, {8'd1, 8'h05, 8'h01});
    rx_byte(8'h01);
    check("R5 close status", {24'd0, sts_rd}, 32'h01);
    txn = 0;
    port_wr(8'h12, 8'h04);
    wait_tx(1);
    repeat (3) @(negedge clk);
    check("R5 rewind single byte", {txn[7:0], txq[0]}, {8'd1, 8'h04});
    rx_byte(8'h00);
  endtask

  task automatic t_ignore();
    txn = 0;
    port_wr(8'h12, 8'h09);
    port_wr(8'h12, 8'h10);
    port_wr(8'h18, 8'h02);
    port_wr(8'h42, 8'h01);
    repeat (10) @(negedge clk);
    check("R12 nothing started", {txn[7:0], sts_rd}, {8'd0, 8'h00});
  endtask

  task automatic t_read_block();
    int bad = 0;
    // DMA set, then changed while busy: the busy writes must be lost
    port_wr(8'h16, 8'hF0);
    port_wr(8'h17, 8'hFF);
    port_wr(8'h12, 8'h05);
    port_wr(8'h16, 8'h00);
    port_wr(8'h17, 8'h02);
    port_wr(8'h13, "Z");
    rx_byte(8'h00);
    txn = 0; wr_cnt = 0;
    port_wr(8'h18, 8'h00);
    wait_tx(1);
    check("R6 block read code", {24'd0, txq[0]}, 32'h10);
    rx_byte(8'h00);
    for (int i = 0; i < 127; i++) rx_byte(8'(i) ^ 8'h5A);
    // last byte and a DMA write in the same cycle
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'd127 ^ 8'h5A;
    pw_valid = 1'b1; pw_port = 8'h16; pw_data = 8'h77;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; pw_valid = 1'b0;
    check("R10 busy after last byte", {24'd0, sts_rd}, 32'h00);
    check("R8 wrap first/last", {wr_first, wr_last}, {16'hFFF0, 16'h006F});
    check("R6 byte count", wr_cnt, 128);
    for (int i = 0; i < 128; i++)
      if (mem[10'((16'hFFF0 + 16'(i)) & 16'h03FF)] !== (8'(i) ^ 8'h5A)) bad++;
    check("R6 stored data", bad, 0);
    wr_cnt = 0; txn = 0;
    port_wr(8'h18, 8'h00);
    rx_byte(8'h00);
    for (int i = 0; i < 128; i++) rx_byte(8'(i));
    check("R10 collided write lost, R8 pointer kept", {16'd0, wr_first}, 32'h0070);
    // name written while busy must not be in the buffer
    txn = 0;
    port_wr(8'h12, 8'h01);
    wait_tx(2);
    repeat (3) @(negedge clk);
    check("R10 name write while busy lost", {txn[7:0], txq[1]}, {8'd2, 8'h00});
    rx_byte(8'h00);
  endtask

  task automatic t_write_block();
    int bad = 0;
    for (int i = 0; i < 128; i++) mem[10'h200 + 10'(i)] = 8'(i * 3 + 1);
    port_wr(8'h16, 8'h00);
    port_wr(8'h17, 8'h02);
    txn = 0;
    stall_en = 1'b1;
    port_wr(8'h18, 8'h01);
    wait_tx(129);
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 frame length", txn, 129);
    check("R7 code", {24'd0, txq[0]}, 32'h11);
    for (int i = 0; i < 128; i++) if (txq[i+1] !== 8'(i * 3 + 1)) bad++;
    check("R7 payload under back-pressure (R13)", bad, 0);
    check("R7 awaiting status", {31'd0, rx_ready}, 32'h1);
    rx_byte(8'h00);
    check("R7 done", {24'd0, sts_rd}, 32'h00);
  endtask

  task automatic t_dir();
    port_wr(8'h16, 8'h00);
    port_wr(8'h17, 8'h03);
    txn = 0; wr_cnt = 0;
    port_wr(8'h12, 8'h06);
    wait_tx(1);
    check("R5 dir single byte", {24'd0, txq[0]}, 32'h06);
    rx_byte(8'h00);
    rx_byte("X");
    rx_byte("Y");
    rx_byte(8'h00);
    check("R11 listing stored", {wr_cnt[7:0], mem[10'h300], mem[10'h301], mem[10'h302]},
          {8'd3, "X", "Y", 8'h00});
    check("R11 listing done", {24'd0, sts_rd}, 32'h00);
    wr_cnt = 0;
    port_wr(8'h12, 8'h06);
    rx_byte(8'h01);
    check("R11 dir error ends", {wr_cnt[7:0], sts_rd}, {8'd0, 8'h01});
    port_wr(8'h18, 8'h00);
    rx_byte(8'h01);
    repeat (3) @(negedge clk);
    check("R11 read error ends", {wr_cnt[7:0], sts_rd, 7'd0, rx_ready}, {8'd0, 8'h01, 8'h00});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_open();
    t_name_limit();
    t_seek();
    t_short();
    t_ignore();
    t_read_block();
    t_write_block();
    t_dir();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule